// File: doc/BRIEF.md
# Reset Release Sequencer with Cause Flags

This block decides when a small controller core may leave reset. A power-on reset (the block's own asynchronous active-low reset), a brown-out pulse and a wake-from-sleep request each start a delay chain. The chain has two stages. The first is a power-up timer that counts ticks of a free-running timer clock. The second is an oscillator start-up counter that counts 1024 edges of the selected oscillator. Which stages run depends on three things: the reset cause, the oscillator mode and an active-low timer-enable bit. When the chain is finished and the external reset pin is high, the core reset is released.

The delay chain runs regardless of the external pin. If the pin is held low past the end of the chain, the core starts within a synchronizer delay of the pin rising. Two software-visible flags record the reset cause. Software sets each flag with a one-cycle set strobe, and the matching reset event clears it. A brown-out during a running chain throws the chain away and starts it again from the beginning.

Top module: `boot_release_seq`

## Requirements
- R1: While `por_n` is low and throughout any running delay, `core_rst_n` is 0. Right after power-on, both `por_flag` and `bor_flag` read 0.
- R2: When `pwrt_off` is 0, the power-up timer runs first for PWRT_CYCLES ticks of `clk`. When `pwrt_off` is 1, the timer is skipped.
- R3: In crystal modes (`osc_mode` 2'b00, 2'b01, 2'b10), the oscillator start-up counter runs for 1024 `osc_clk` edges. It starts only after the power-up timer, when that timer runs.
- R4: In the non-crystal mode (`osc_mode` 2'b11), the start-up counter never runs. The delay is the power-up timer alone, or zero when `pwrt_off` is 1.
- R5: A brown-out pulse (`bor_pulse` high for one `clk` cycle) starts the same delay chain as power-on.
- R6: A `wake_req` strobe while the core runs gives a delay of 1024 oscillator edges in crystal modes. In mode 2'b11 it has no effect on `core_rst_n`.
- R7: The delays run whatever `ext_pin_n` does. If the pin is low when they end, `core_rst_n` rises within 3 `clk` cycles of the pin going high.
- R8: `por_flag` is cleared only by power-on. A brown-out leaves it unchanged. `sw_set_por` sets it to 1.
- R9: A brown-out clears `bor_flag` to 0. `sw_set_bor` sets it to 1, and a brown-out in the same cycle takes priority.
- R10: A brown-out during a running delay restarts the whole chain, so the release comes no earlier than a full chain after the second pulse.
- R11: Holding `ext_pin_n` low does not change either status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| osc_clk | input | 1 | Selected oscillator, counted during start-up |
| bor_pulse | input | 1 | Brown-out event, one `clk` cycle, active high |
| ext_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wake_req | input | 1 | Wake-from-sleep strobe, one `clk` cycle |
| pwrt_off | input | 1 | 1 skips the power-up timer |
| osc_mode | input | 2 | 00/01/10 crystal modes, 11 RC/external/internal |
| sw_set_por | input | 1 | Software strobe that sets `por_flag` |
| sw_set_bor | input | 1 | Software strobe that sets `bor_flag` |
| core_rst_n | output | 1 | Core reset, active low |
| por_flag | output | 1 | Power-on cause flag (0 after power-on) |
| bor_flag | output | 1 | Brown-out cause flag (0 after brown-out) |

## Verification
The release delay is measured for every combination that changes the chain: power-on, brown-out and wake; timer enabled and disabled; crystal and non-crystal modes. The expected delays are distinct, so a missing or extra stage shows up as a different measurement. Directed cases cover three situations:
- a pin held low past the chain, which separates pin gating from the chain's own timing;
- a second brown-out in the middle of a sequence, which separates a restart from a continuation;
- flag strobes interleaved with brown-outs and pin activity, which separate the clear sources of the two flags.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_START  = 3'd0,
    ST_PWRT   = 3'd1,
    ST_OSTCLR = 3'd2,
    ST_OST    = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_t;

  localparam logic [1:0] MODE_NOXTAL = 2'b11;
endpackage

// File: rtl/boot_sync2.sv
module boot_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/boot_pwrt_timer.sv
module boot_pwrt_timer #(
  parameter int CYCLES = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = en && (cnt_q == LAST);
endmodule

// File: rtl/boot_ost_counter.sv
module boot_ost_counter #(
  parameter int EDGES = 1024
) (
  input  logic osc_clk,
  input  logic por_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic orst_n, start_s;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;

  boot_sync2 u_rsync (.clk(osc_clk), .rst_n(por_n), .d(1'b1), .q(orst_n));
  boot_sync2 u_ssync (.clk(osc_clk), .rst_n(orst_n), .d(start), .q(start_s));

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!start_s) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge osc_clk or negedge orst_n) begin
    if (!orst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/boot_release_seq.sv
module boot_release_seq
  import boot_seq_pkg::*;
#(
  parameter int PWRT_CYCLES = 72,
  parameter int OST_EDGES   = 1024
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       osc_clk,
  input  logic       bor_pulse,
  input  logic       ext_pin_n,
  input  logic       wake_req,
  input  logic       pwrt_off,
  input  logic [1:0] osc_mode,
  input  logic       sw_set_por,
  input  logic       sw_set_bor,
  output logic       core_rst_n,
  output logic       por_flag,
  output logic       bor_flag
);
  logic rst_s, ext_s, done_s, pw_exp, xtal;
  seq_state_t state_q, state_d;
  logic ost_start_q, ost_start_d;
  logic ost_done;
  logic porf_q, porf_d, borf_q, borf_d;

  boot_sync2 u_rsync (.clk(clk), .rst_n(por_n), .d(1'b1), .q(rst_s));
  boot_sync2 u_psync (.clk(clk), .rst_n(rst_s), .d(ext_pin_n), .q(ext_s));
  boot_sync2 u_dsync (.clk(clk), .rst_n(rst_s), .d(ost_done), .q(done_s));

  boot_pwrt_timer #(.CYCLES(PWRT_CYCLES)) u_pwrt (
    .clk(clk), .rst_n(rst_s), .en(state_q == ST_PWRT), .expire(pw_exp)
  );

  boot_ost_counter #(.EDGES(OST_EDGES)) u_ost (
    .osc_clk(osc_clk), .por_n(por_n), .start(ost_start_q), .done(ost_done)
  );

  assign xtal = (osc_mode != MODE_NOXTAL);

  // next state of the release sequence
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_START:  state_d = !pwrt_off ? ST_PWRT : (xtal ? ST_OSTCLR : ST_RUN);
      ST_PWRT:   if (pw_exp) state_d = xtal ? ST_OSTCLR : ST_RUN;
      ST_OSTCLR: if (!done_s) state_d = ST_OST;
      ST_OST:    if (done_s) state_d = ST_RUN;
      ST_RUN:    if (wake_req && xtal) state_d = ST_OSTCLR;
      default:   state_d = ST_START;
    endcase
    if (bor_pulse) state_d = ST_START;
    ost_start_d = (state_d == ST_OST);
  end

  // cause flags
  always_comb begin
    porf_d = porf_q;
    borf_d = borf_q;
    if (sw_set_por) porf_d = 1'b1;
    if (bor_pulse)       borf_d = 1'b0;
    else if (sw_set_bor) borf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q     <= ST_START;
      ost_start_q <= 1'b0;
      porf_q      <= 1'b0;
      borf_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      ost_start_q <= ost_start_d;
      porf_q      <= porf_d;
      borf_q      <= borf_d;
    end
  end

  assign core_rst_n = (state_q == ST_RUN) && ext_s;
  assign por_flag   = porf_q;
  assign bor_flag   = borf_q;
endmodule

// File: rtl/boot_release_chk.sv
module boot_release_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bor_pulse,
  input logic       ext_pin_n,
  input logic       wake_req,
  input logic [1:0] osc_mode,
  input logic       sw_set_por,
  input logic       core_rst_n,
  input logic       por_flag,
  input logic       bor_flag
);
  p_bor_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bor_pulse |=> !bor_flag);

  p_bor_keeps_por_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_pulse && !sw_set_por) |=> (por_flag == $past(por_flag)));

  p_bor_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bor_pulse |=> !core_rst_n);

  p_pin_low_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_pin_n && $past(!ext_pin_n)) |=> !core_rst_n);

  p_wake_noxtal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && core_rst_n && osc_mode == 2'b11 && !bor_pulse && $past(ext_pin_n))
      |=> core_rst_n);
endmodule

bind boot_release_seq boot_release_chk u_chk (
  .clk(clk), .rst_n(por_n), .bor_pulse(bor_pulse), .ext_pin_n(ext_pin_n),
  .wake_req(wake_req), .osc_mode(osc_mode), .sw_set_por(sw_set_por),
  .core_rst_n(core_rst_n), .por_flag(por_flag), .bor_flag(bor_flag)
);

// File: tb/boot_release_seq_tb.sv
module boot_release_seq_tb;
  logic clk = 1'b0, osc_clk = 1'b0;
  logic por_n = 1'b0, bor_pulse = 1'b0, ext_pin_n = 1'b1, wake_req = 1'b0;
  logic pwrt_off = 1'b0, sw_set_por = 1'b0, sw_set_bor = 1'b0;
  logic [1:0] osc_mode = 2'b11;
  logic core_rst_n, por_flag, bor_flag;

  int total = 0, bad = 0;
  localparam int WIN = 24;
  // 72 ticks of timer; 1024 edges of a 4 ns oscillator = 409 ticks of 10 ns
  // fields: [15:14] kind 0=power-on 1=brown-out 2=wake, [13] pwrt_off,
  //         [12:11] osc_mode, [10:0] minimum delay in clk cycles
  localparam logic [15:0] VEC [9] = '{
    {2'd0, 1'b0, 2'b01, 11'd481},
    {2'd0, 1'b1, 2'b00, 11'd409},
    {2'd0, 1'b0, 2'b11, 11'd72},
    {2'd0, 1'b1, 2'b11, 11'd0},
    {2'd1, 1'b0, 2'b10, 11'd481},
    {2'd1, 1'b1, 2'b11, 11'd0},
    {2'd1, 1'b1, 2'b01, 11'd409},
    {2'd2, 1'b0, 2'b00, 11'd409},
    {2'd2, 1'b0, 2'b11, 11'd0}
  };

  always #5 clk = ~clk;
  always #2 osc_clk = ~osc_clk;

  boot_release_seq u_dut (
    .clk(clk), .por_n(por_n), .osc_clk(osc_clk), .bor_pulse(bor_pulse),
    .ext_pin_n(ext_pin_n), .wake_req(wake_req), .pwrt_off(pwrt_off),
    .osc_mode(osc_mode), .sw_set_por(sw_set_por), .sw_set_bor(sw_set_bor),
    .core_rst_n(core_rst_n), .por_flag(por_flag), .bor_flag(bor_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (core_rst_n) break;
      n++;
    end
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(core_rst_n == 1'b0, "R1 reset held in power-on", int'(core_rst_n), 0);
    chk(por_flag == 1'b0, "R8 por_flag after power-on", int'(por_flag), 0);
    chk(bor_flag == 1'b0, "R9 bor_flag after power-on", int'(bor_flag), 0);
    por_n = 1'b1;
  endtask

  task automatic pulse_bor();
    @(negedge clk); bor_pulse = 1'b1;
    @(negedge clk); bor_pulse = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // delay chain table: R2 R3 R4 R5 R6
    for (int v = 0; v < 9; v++) begin
      logic [1:0] kind;
      int lo;
      kind = VEC[v][15:14];
      lo   = int'(VEC[v][10:0]);
      @(negedge clk);
      pwrt_off = VEC[v][13];
      osc_mode = VEC[v][12:11];
      if (kind == 2'd0) do_por();
      else if (kind == 2'd1) pulse_bor();
      else begin
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
      end
      measure(n);
      chk(n >= lo && n <= lo + WIN, "R2/R3/R4 chain length (R5 R6)", n, lo);
    end

    // R1 + R7: pin held low past the chain
    @(negedge clk); pwrt_off = 1'b0; osc_mode = 2'b11; ext_pin_n = 1'b0;
    do_por();
    repeat (200) @(negedge clk);
    chk(core_rst_n == 1'b0, "R7 pin low keeps reset", int'(core_rst_n), 0);
    ext_pin_n = 1'b1;
    measure(n);
    chk(n >= 1 && n <= 3, "R7 release after pin rises", n, 2);

    // R8 R9: software sets, brown-out clears bor only
    @(negedge clk); sw_set_por = 1'b1; sw_set_bor = 1'b1;
    @(negedge clk); sw_set_por = 1'b0; sw_set_bor = 1'b0;
    chk(por_flag == 1'b1, "R8 sw set por_flag", int'(por_flag), 1);
    chk(bor_flag == 1'b1, "R9 sw set bor_flag", int'(bor_flag), 1);

    // R11: pin activity leaves flags alone
    ext_pin_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(core_rst_n == 1'b0, "R7 pin low asserts reset", int'(core_rst_n), 0);
    chk(por_flag == 1'b1 && bor_flag == 1'b1, "R11 flags after pin low",
        int'({por_flag, bor_flag}), 3);
    ext_pin_n = 1'b1;
    measure(n);

    // R9 priority: brown-out beats set strobe
    @(negedge clk); bor_pulse = 1'b1; sw_set_bor = 1'b1;
    @(negedge clk); bor_pulse = 1'b0; sw_set_bor = 1'b0;
    chk(bor_flag == 1'b0, "R9 brown-out clears bor_flag", int'(bor_flag), 0);
    chk(por_flag == 1'b1, "R8 brown-out keeps por_flag", int'(por_flag), 1);
    measure(n);

    // R10: restart in the middle of a sequence
    @(negedge clk); pwrt_off = 1'b0; osc_mode = 2'b01;
    pulse_bor();
    repeat (300) @(negedge clk);
    chk(core_rst_n == 1'b0, "R10 mid-sequence reset held", int'(core_rst_n), 0);
    pulse_bor();
    measure(n);
    chk(n >= 481 && n <= 481 + WIN, "R10 full chain after restart", n, 481);

    // R8: power-on clears por_flag again
    do_por();
    measure(n);
    chk(por_flag == 1'b0, "R8 por_flag after second power-on", int'(por_flag), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule